// File: doc/BRIEF.md
# Multi-source configurable I/O port

This block is an eight-bit general-purpose I/O port in which every pin is set up on its own. A host reaches it through a small register space with a 3-bit offset. That space holds a data-out register, a direction register and a per-pin control register. For each pin, an output selector decides what drives the pad. The choices are the data-out bit, a bit of a host address captured under an address-latch strobe, an external programmable-logic output, or an external chip-select line.

The control bit of a pin picks between the data-out register and an alternate source. A static configuration input, two bits per pin, names which alternate source is allowed. The same configuration lets a product-term enable input take part in the pin's output enable. A shared readback path presents exactly one source on the read data bus at a time. The sources are the synchronized pin levels, the data-out, direction and control registers, or the live logic outputs. Pad drive leaves the block as separate output-value and output-enable vectors; the logic array and the pad cells sit outside.

The port has no sequencer. Its behaviour is set by the registers and the address latch. Each of these updates on the clock edge that samples its strobe.

Top module: `cfg_io_port`

## Requirements
- R1: After reset the data-out, direction, control and address-latch registers are all zero, so `pad_oe` and `pad_out` are zero and every pin is an input.
- R2: A write with `reg_wr` high updates the addressed register on that clock edge. Offset 1 is data-out, offset 2 is direction and offset 3 is control. A read of the same offset then returns the written value.
- R3: Writes to offset 0 (pin levels), offset 4 (logic readback) and offsets 5 to 7 leave the data-out, direction and control registers unchanged.
- R4: A pin whose control bit is 0 drives its data-out bit on `pad_out`.
- R5: With its control bit at 1 and configuration code 1, a pin drives the address-latch bit. The latch loads `addr` on a clock edge where `ale` is high and holds its value otherwise.
- R6: With its control bit at 1, a pin drives a source chosen by its 2-bit configuration field `cfg_alt[2i+1:2i]`. Code 2 selects `mcell[i]`, code 3 selects `csel[i]` and code 0 selects the data-out bit.
- R7: `pad_oe[i]` is 1 when direction bit i is 1, or when the pin is in a logic-driven mode (control bit 1 with code 2 or 3) and `pt_oe[i]` is 1. In every other case it is 0.
- R8: A read of offset 0 returns the pin levels `pad_in` delayed by two clock edges.
- R9: A read of offset 4 returns the current `mcell` inputs.
- R10: `rd_data` is zero while `reg_rd` is low. A read of offsets 5 to 7 also returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | W | Write data |
| rd_data | output | W | Read data, combinational while `reg_rd` is high |
| ale | input | 1 | Address-latch enable |
| addr | input | W | Host address bits for the latch |
| cfg_alt | input | 2*W | Static per-pin alternate-source code |
| mcell | input | W | External logic outputs |
| csel | input | W | External chip-select lines |
| pt_oe | input | W | Product-term output enables |
| pad_in | input | W | Pin levels from the pads |
| pad_out | output | W | Output value to the pads |
| pad_oe | output | W | Output enable to the pads |

## Verification
The bench uses the defaults: a width of 8 and two synchronizer stages. With a width of 8, all four configuration codes can appear on different pins in the same cycle. Random per-pin mixes then show how the source selection and the output-enable rule interact. The two-stage depth keeps the delay on the pin-level readback short, so a directed step can catch the old value one edge in and the new value two edges in.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;
    typedef enum logic [1:0] {
        SRC_DOUT  = 2'd0,
        SRC_ADDR  = 2'd1,
        SRC_MCELL = 2'd2,
        SRC_CSEL  = 2'd3
    } src_e;

    localparam int OFF_W = 3;
    localparam logic [OFF_W-1:0] OFF_DIN   = 3'd0;
    localparam logic [OFF_W-1:0] OFF_DOUT  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_DIR   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CTL   = 3'd3;
    localparam logic [OFF_W-1:0] OFF_MCELL = 3'd4;
endpackage

// File: rtl/ioport_regs.sv
module ioport_regs
    import cfg_io_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     dout_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     ctl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
            ctl_q  <= '0;
        end else if (wr) begin
            case (off)
                OFF_DOUT: dout_q <= wdata;
                OFF_DIR:  dir_q  <= wdata;
                OFF_CTL:  ctl_q  <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/ioport_addr_latch.sv
module ioport_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] addr,
    output logic [W-1:0] alat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   alat_q <= '0;
        else if (ale) alat_q <= addr;
    end
endmodule

// File: rtl/ioport_sync.sv
module ioport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ioport_pin_mux.sv
module ioport_pin_mux
    import cfg_io_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   ctl_q,
    input  logic [2*W-1:0] cfg_alt,
    input  logic [W-1:0]   dout_q,
    input  logic [W-1:0]   alat_q,
    input  logic [W-1:0]   mcell,
    input  logic [W-1:0]   csel,
    input  logic [W-1:0]   dir_q,
    input  logic [W-1:0]   pt_oe,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        src_e sel;
        logic bit_out;
        logic logic_mode;

        assign sel = ctl_q[i] ? src_e'(cfg_alt[2*i +: 2]) : SRC_DOUT;

        always_comb begin
            unique case (sel)
                SRC_DOUT:  bit_out = dout_q[i];
                SRC_ADDR:  bit_out = alat_q[i];
                SRC_MCELL: bit_out = mcell[i];
                SRC_CSEL:  bit_out = csel[i];
                default:   bit_out = dout_q[i];
            endcase
        end

        assign logic_mode = (sel == SRC_MCELL) || (sel == SRC_CSEL);
        assign pad_out[i] = bit_out;
        assign pad_oe[i]  = dir_q[i] | (logic_mode & pt_oe[i]);
    end
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
    import cfg_io_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     rd_data,
    input  logic             ale,
    input  logic [W-1:0]     addr,
    input  logic [2*W-1:0]   cfg_alt,
    input  logic [W-1:0]     mcell,
    input  logic [W-1:0]     csel,
    input  logic [W-1:0]     pt_oe,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe
);
    logic [W-1:0] dout_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] ctl_q;
    logic [W-1:0] alat_q;
    logic [W-1:0] din_s;

    ioport_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .off    (reg_off),
        .wdata  (reg_wdata),
        .dout_q (dout_q),
        .dir_q  (dir_q),
        .ctl_q  (ctl_q)
    );

    ioport_addr_latch #(.W(W)) u_alat (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale    (ale),
        .addr   (addr),
        .alat_q (alat_q)
    );

    ioport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (din_s)
    );

    ioport_pin_mux #(.W(W)) u_mux (
        .ctl_q   (ctl_q),
        .cfg_alt (cfg_alt),
        .dout_q  (dout_q),
        .alat_q  (alat_q),
        .mcell   (mcell),
        .csel    (csel),
        .dir_q   (dir_q),
        .pt_oe   (pt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Shared readback: one source on the bus, zero when idle.
    always_comb begin
        rd_data = '0;
        if (reg_rd) begin
            case (reg_off)
                OFF_DIN:   rd_data = din_s;
                OFF_DOUT:  rd_data = dout_q;
                OFF_DIR:   rd_data = dir_q;
                OFF_CTL:   rd_data = ctl_q;
                OFF_MCELL: rd_data = mcell;
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk
    import cfg_io_port_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [OFF_W-1:0] reg_off,
    input logic [W-1:0]     reg_wdata,
    input logic [W-1:0]     rd_data,
    input logic             ale,
    input logic [W-1:0]     addr,
    input logic [W-1:0]     pad_out,
    input logic [W-1:0]     pad_oe,
    input logic [W-1:0]     dout_q,
    input logic [W-1:0]     dir_q,
    input logic [W-1:0]     ctl_q,
    input logic [W-1:0]     alat_q
);
    p_wr_dout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == OFF_DOUT) |=> dout_q == $past(reg_wdata));

    p_rd_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_off == OFF_DIR) |-> rd_data == dir_q);

    p_ro_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_off == OFF_DIN || reg_off >= OFF_MCELL))
        |=> ($stable(dout_q) && $stable(dir_q) && $stable(ctl_q)));

    p_dout_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ctl_q & (pad_out ^ dout_q)) == '0));

    p_latch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> alat_q == $past(addr));

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(alat_q));

    p_dir_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~pad_oe) == '0));

    p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> rd_data == '0);
endmodule

bind cfg_io_port cfg_io_port_chk #(.W(W)) u_chk (.*);

// File: tb/cfg_io_port_test.sv
module cfg_io_port_test;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           reg_wr, reg_rd, ale;
    logic [2:0]     reg_off;
    logic [W-1:0]   reg_wdata, rd_data, addr, mcell, csel, pt_oe, pad_in, pad_out, pad_oe;
    logic [2*W-1:0] cfg_alt;

    logic [W-1:0] m_dout, m_dir, m_ctl, m_alat, m_s1, m_s2;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_io_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .rd_data(rd_data),
        .ale(ale), .addr(addr), .cfg_alt(cfg_alt), .mcell(mcell),
        .csel(csel), .pt_oe(pt_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [W-1:0] f_out();
        logic [W-1:0] o;
        for (int i = 0; i < W; i++) begin
            if (!m_ctl[i]) o[i] = m_dout[i];
            else case (cfg_alt[2*i +: 2])
                2'd1:    o[i] = m_alat[i];
                2'd2:    o[i] = mcell[i];
                2'd3:    o[i] = csel[i];
                default: o[i] = m_dout[i];
            endcase
        end
        return o;
    endfunction

    function automatic logic [W-1:0] f_oe();
        logic [W-1:0] o;
        for (int i = 0; i < W; i++)
            o[i] = m_dir[i] | (m_ctl[i] & cfg_alt[2*i+1] & pt_oe[i]);
        return o;
    endfunction

    function automatic logic [W-1:0] f_rd(input logic [2:0] off);
        case (off)
            3'd0:    return m_s2;
            3'd1:    return m_dout;
            3'd2:    return m_dir;
            3'd3:    return m_ctl;
            3'd4:    return mcell;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply model effects of the inputs held across the coming edge.
    task automatic tick();
        if (reg_wr) begin
            case (reg_off)
                3'd1: m_dout = reg_wdata;
                3'd2: m_dir  = reg_wdata;
                3'd3: m_ctl  = reg_wdata;
                default: ;
            endcase
        end
        if (ale) m_alat = addr;
        m_s2 = m_s1;
        m_s1 = pad_in;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] off, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_off = off; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [W-1:0] d);
        reg_rd = 1'b1; reg_off = off;
        #1 d = rd_data;
        reg_rd = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd4242));
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; ale = 0; reg_off = 0;
        reg_wdata = 0; addr = 0; cfg_alt = 0; mcell = 0; csel = 0;
        pt_oe = 0; pad_in = 0;
        m_dout = 0; m_dir = 0; m_ctl = 0; m_alat = 0; m_s1 = 0; m_s2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, 0);
        check("R1 pad_out", pad_out, 0);
        for (int o = 1; o < 4; o++) begin
            rd(3'(o), v); check("R1 reg zero", v, 0);
        end

        // R2 writes and readback
        wr(3'd1, 8'hA5); wr(3'd2, 8'h0F); wr(3'd3, 8'h00);
        rd(3'd1, v); check("R2 dout", v, 8'hA5);
        rd(3'd2, v); check("R2 dir", v, 8'h0F);
        rd(3'd3, v); check("R2 ctl", v, 8'h00);
        check("R4 dout on pins", pad_out, 8'hA5);

        // R3 read-only and unused offsets ignore writes
        wr(3'd0, 8'hFF); wr(3'd4, 8'hFF); wr(3'd7, 8'h5A);
        rd(3'd1, v); check("R3 dout kept", v, 8'hA5);
        rd(3'd2, v); check("R3 dir kept", v, 8'h0F);
        rd(3'd3, v); check("R3 ctl kept", v, 8'h00);

        // R10 idle bus and unused offsets
        reg_off = 3'd1; #1 check("R10 idle bus", rd_data, 0);
        for (int o = 5; o < 8; o++) begin
            rd(3'(o), v); check("R10 unused offset", v, 0);
        end

        // R9 logic readback
        mcell = 8'h3C; rd(3'd4, v); check("R9 mcell readback", v, 8'h3C);

        // R8 two-edge pin synchronizer
        pad_in = 8'h96; tick();
        rd(3'd0, v); check("R8 one edge", v, 8'h00);
        tick();
        rd(3'd0, v); check("R8 two edges", v, 8'h96);

        // R5 address latch source
        wr(3'd3, 8'hFF); cfg_alt = {W{2'd1}};
        ale = 1; addr = 8'hC3; tick(); ale = 0; addr = 8'h11;
        check("R5 latched addr", pad_out, 8'hC3);
        tick();
        check("R5 latch hold", pad_out, 8'hC3);

        // R6 other alternate sources
        csel = 8'h81;
        cfg_alt = {W{2'd2}}; #1 check("R6 mcell source", pad_out, 8'h3C);
        cfg_alt = {W{2'd3}}; #1 check("R6 csel source", pad_out, 8'h81);
        cfg_alt = {W{2'd0}}; #1 check("R6 code0 dout", pad_out, 8'hA5);

        // R7 output enable
        wr(3'd2, 8'h00); pt_oe = 8'hFF;
        cfg_alt = {W{2'd3}}; #1 check("R7 pt enable logic mode", pad_oe, 8'hFF);
        cfg_alt = {W{2'd1}}; #1 check("R7 no pt in addr mode", pad_oe, 8'h00);
        wr(3'd3, 8'h00); cfg_alt = {W{2'd2}};
        #1 check("R7 no pt when ctl 0", pad_oe, 8'h00);

        // Random mix: R4 R5 R6 R7 and readback R2 R8 R9
        for (int k = 0; k < 400; k++) begin
            reg_wr    = ($urandom % 3) == 0;
            reg_off   = 3'($urandom % 8);
            reg_wdata = W'($urandom);
            ale       = $urandom % 2;
            addr      = W'($urandom);
            cfg_alt   = (2*W)'($urandom);
            mcell     = W'($urandom);
            csel      = W'($urandom);
            pt_oe     = W'($urandom);
            pad_in    = W'($urandom);
            tick();
            reg_wr = 1'b0;
            check("R4 R6 random pad_out", pad_out, f_out());
            check("R7 random pad_oe", pad_oe, f_oe());
            begin
                logic [2:0] ro;
                ro = 3'($urandom % 8);
                rd(ro, v);
                check("R2 R8 R9 random readback", v, f_rd(ro));
            end
        end

        summary();
        $finish;
    end
endmodule